// File: doc/BRIEF.md
# Privilege Mode and Trap Controller

This block holds the processor's privilege state. The state is either monitor (supervisor) or user. For each decoded instruction the block decides whether it may execute. It raises an illegal-instruction trap in three cases: a privileged instruction issued in user mode, an undefined opcode, or a channel-control load or store issued while no channel processor is fitted. A privileged instruction caught in user mode also sets a sticky violation flag. Software can later read that flag and clear it with dedicated commands.

The machine always returns to monitor mode on three events: an initialize pulse, any interrupt being taken, or a trap being requested. A single command moves it from monitor to user mode. That command also emits a one-cycle strobe that switches the interrupt system on. While the machine is in user mode, instructions that would write the interrupt-enable flag still execute, but their flag write is suppressed. The interrupt system therefore stays enabled until an interrupt brings the machine back to monitor mode. A test command returns one selected bit on a single zero-flag output in the same cycle.

Top module: `priv_trap_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `user_mode_o` is 0 (monitor), `pv_flag_o` is 0, `trap_req_o` is 0 and `ie_set_o` is 0.
- R2: A cycle with `init_i` or `irq_taken_i` high makes `user_mode_o` 0 from the next clock edge, whatever the current mode.
- R3: In monitor mode, `cmd_user_i` with no trap, `init_i` or `irq_taken_i` in the same cycle drives `ie_set_o` to 1 in that cycle and sets `user_mode_o` to 1 at the next edge. In user mode, `cmd_user_i` has no effect and `ie_set_o` stays 0.
- R4: In user mode, a valid instruction with `insn_priv_i` high drives `trap_req_o` and `exec_inhibit_o` to 1 in the same cycle. At the next edge `pv_flag_o` becomes 1 and `user_mode_o` becomes 0.
- R5: A valid instruction with `insn_undef_i` high, or with `insn_chan_i` high while `chanproc_present_i` is 0, drives `trap_req_o` and `exec_inhibit_o` to 1 in either mode and leaves `pv_flag_o` unchanged. Any trap returns the machine to monitor mode at the next edge.
- R6: In monitor mode, privileged instructions raise no trap and no inhibit. Channel-control instructions raise none while `chanproc_present_i` is 1. When `insn_valid_i` is 0, no trap is raised in either mode.
- R7: A valid instruction with `insn_eflag_i` high and no trap executes (`exec_inhibit_o` 0). `eflag_wr_o` is 1 for it in monitor mode and 0 in user mode.
- R8: In monitor mode, `zflag_o` equals 1 during `cmd_test_mode_i` and equals `pv_flag_o` during `cmd_test_pv_i`, in the same cycle. In user mode, `zflag_o` is 0 and `cmd_clr_pv_i` has no effect.
- R9: In monitor mode, `cmd_clr_pv_i` clears `pv_flag_o` at the next edge.
- R10: If `cmd_user_i` and a trap request occur in the same monitor-mode cycle, the trap wins: `ie_set_o` stays 0 and `user_mode_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Initialize pulse, forces monitor mode |
| irq_taken_i | input | 1 | An interrupt was taken this cycle |
| insn_valid_i | input | 1 | A decoded instruction is presented |
| insn_priv_i | input | 1 | Instruction is privileged |
| insn_undef_i | input | 1 | Opcode is undefined |
| insn_chan_i | input | 1 | Instruction is a channel-control load/store |
| insn_eflag_i | input | 1 | Instruction writes the interrupt-enable flag |
| chanproc_present_i | input | 1 | Strap: channel processor fitted |
| cmd_user_i | input | 1 | Command: leave monitor mode, enable interrupts |
| cmd_test_mode_i | input | 1 | Command: report monitor mode on zflag_o |
| cmd_test_pv_i | input | 1 | Command: report violation flag on zflag_o |
| cmd_clr_pv_i | input | 1 | Command: clear violation flag |
| user_mode_o | output | 1 | 1 = user mode, 0 = monitor mode |
| exec_inhibit_o | output | 1 | Current instruction must not execute |
| trap_req_o | output | 1 | Illegal-instruction trap request |
| pv_flag_o | output | 1 | Sticky privileged-violation flag |
| eflag_wr_o | output | 1 | Gated interrupt-enable flag write strobe |
| ie_set_o | output | 1 | One-cycle strobe forcing interrupts on |
| zflag_o | output | 1 | Test result bit |

## Verification
Four outputs are combinational and are due in the same cycle as their stimulus: the trap request, the execute inhibit, the gated flag write and the zero-flag test result. The enable strobe is also due in that cycle. The mode and the violation flag are registered, so they change at the first clock edge after the stimulus. The bench drives inputs just after a rising edge. It samples the same-cycle results at the following falling edge. It removes the stimulus after the next rising edge and reads the registered results at the falling edge that follows.

// File: rtl/priv_trap_pkg.sv
// Package: shared types for the privilege mode and trap controller.
// Assumes a single-bit mode state and a four-bit instruction class.
package priv_trap_pkg;

    typedef enum logic {
        MODE_MON  = 1'b0,
        MODE_USER = 1'b1
    } pmode_e;

    typedef struct packed {
        logic priv;
        logic undef;
        logic chan;
        logic eflag;
    } insn_cls_t;

    localparam pmode_e RESET_MODE = MODE_MON;

endpackage

// File: rtl/priv_insn_gate.sv
// Module: priv_insn_gate
// Decides, in the cycle an instruction is presented, whether it traps, is
// inhibited, sets the violation flag, or may write the enable flag.
// Assumes the class bits are only meaningful while valid is high.
module priv_insn_gate
    import priv_trap_pkg::*;
(
    input  pmode_e    mode_i,
    input  logic      valid_i,
    input  insn_cls_t cls_i,
    input  logic      present_i,
    output logic      trap_o,
    output logic      inhibit_o,
    output logic      pv_set_o,
    output logic      eflag_wr_o
);

    logic in_user;
    logic priv_hit;
    logic illegal_hit;

    // classify the presented instruction against the current mode
    always_comb begin
        in_user     = (mode_i == MODE_USER);
        priv_hit    = valid_i && cls_i.priv && in_user;
        illegal_hit = valid_i && (cls_i.undef || (cls_i.chan && !present_i));
        trap_o      = priv_hit || illegal_hit;
        inhibit_o   = trap_o;
        pv_set_o    = priv_hit;
        eflag_wr_o  = valid_i && cls_i.eflag && !trap_o && !in_user;
    end

endmodule

// File: rtl/priv_mode_reg.sv
// Module: priv_mode_reg
// Holds the monitor/user mode bit. Forced to monitor by any force event;
// enters user mode on request only from monitor with no force pending.
// Assumes force events take priority over the enter request.
module priv_mode_reg
    import priv_trap_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   force_mon_i,
    input  logic   enter_user_i,
    output pmode_e mode_o,
    output logic   ie_set_o
);

    pmode_e mode_q;
    logic   accept;

    // accept the enter request only from monitor and with no force event
    always_comb begin
        accept   = enter_user_i && (mode_q == MODE_MON) && !force_mon_i;
        ie_set_o = accept;
    end

    // mode state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= RESET_MODE;
        end else if (force_mon_i) begin
            mode_q <= MODE_MON;
        end else if (accept) begin
            mode_q <= MODE_USER;
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/priv_flag_reg.sv
// Module: priv_flag_reg
// Sticky privileged-violation flag with its test and clear commands,
// and the zero-flag test result multiplexer.
// Assumes commands are honoured only in monitor mode.
module priv_flag_reg
    import priv_trap_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  pmode_e mode_i,
    input  logic   set_i,
    input  logic   clr_i,
    input  logic   test_pv_i,
    input  logic   test_mode_i,
    output logic   flag_o,
    output logic   zflag_o
);

    logic flag_q;
    logic in_mon;

    // test result selection, valid only in monitor mode
    always_comb begin
        in_mon  = (mode_i == MODE_MON);
        zflag_o = in_mon && ((test_mode_i) || (test_pv_i && flag_q));
    end

    // sticky flag: set has priority over a monitor-mode clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i && in_mon) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/priv_trap_ctrl.sv
// Module: priv_trap_ctrl (top)
// Privilege mode and illegal-instruction trap controller. Combines the
// instruction gate, the mode register and the violation flag register.
// Assumes one instruction per cycle and commands already decoded to strobes.
module priv_trap_ctrl
    import priv_trap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic irq_taken_i,
    input  logic insn_valid_i,
    input  logic insn_priv_i,
    input  logic insn_undef_i,
    input  logic insn_chan_i,
    input  logic insn_eflag_i,
    input  logic chanproc_present_i,
    input  logic cmd_user_i,
    input  logic cmd_test_mode_i,
    input  logic cmd_test_pv_i,
    input  logic cmd_clr_pv_i,
    output logic user_mode_o,
    output logic exec_inhibit_o,
    output logic trap_req_o,
    output logic pv_flag_o,
    output logic eflag_wr_o,
    output logic ie_set_o,
    output logic zflag_o
);

    insn_cls_t cls;
    pmode_e    mode;
    logic      trap;
    logic      pv_set;
    logic      force_mon;

    // gather class bits and the events that force monitor mode
    always_comb begin
        cls.priv  = insn_priv_i;
        cls.undef = insn_undef_i;
        cls.chan  = insn_chan_i;
        cls.eflag = insn_eflag_i;
        force_mon = init_i || irq_taken_i || trap;
    end

    priv_insn_gate u_gate (
        .mode_i     (mode),
        .valid_i    (insn_valid_i),
        .cls_i      (cls),
        .present_i  (chanproc_present_i),
        .trap_o     (trap),
        .inhibit_o  (exec_inhibit_o),
        .pv_set_o   (pv_set),
        .eflag_wr_o (eflag_wr_o)
    );

    priv_mode_reg u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .force_mon_i  (force_mon),
        .enter_user_i (cmd_user_i),
        .mode_o       (mode),
        .ie_set_o     (ie_set_o)
    );

    priv_flag_reg u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .set_i       (pv_set),
        .clr_i       (cmd_clr_pv_i),
        .test_pv_i   (cmd_test_pv_i),
        .test_mode_i (cmd_test_mode_i),
        .flag_o      (pv_flag_o),
        .zflag_o     (zflag_o)
    );

    assign trap_req_o  = trap;
    assign user_mode_o = (mode == MODE_USER);

endmodule

// File: rtl/priv_trap_ctrl_chk.sv
// Module: priv_trap_ctrl_chk
// Property checker bound to priv_trap_ctrl; observes ports only.
module priv_trap_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic init_i,
    input logic irq_taken_i,
    input logic insn_valid_i,
    input logic insn_priv_i,
    input logic insn_undef_i,
    input logic insn_chan_i,
    input logic chanproc_present_i,
    input logic cmd_user_i,
    input logic user_mode_o,
    input logic exec_inhibit_o,
    input logic trap_req_o,
    input logic pv_flag_o,
    input logic eflag_wr_o,
    input logic ie_set_o
);

    p_force_mon_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (init_i || irq_taken_i) |=> !user_mode_o);

    p_ie_enters_user_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ie_set_o |=> user_mode_o);

    p_priv_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid_i && insn_priv_i && user_mode_o) |=> (pv_flag_o && !user_mode_o));

    p_undef_traps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid_i && insn_undef_i) |-> (trap_req_o && exec_inhibit_o));

    p_flag_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pv_flag_o) |-> $past(insn_valid_i && insn_priv_i && user_mode_o));

    p_mon_no_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!user_mode_o && insn_valid_i && !insn_undef_i
         && !(insn_chan_i && !chanproc_present_i)) |-> !exec_inhibit_o);

    p_user_no_eflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode_o |-> !eflag_wr_o);

    p_trap_beats_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req_o && cmd_user_i) |-> (!ie_set_o ##1 !user_mode_o));

endmodule

bind priv_trap_ctrl priv_trap_ctrl_chk u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .init_i             (init_i),
    .irq_taken_i        (irq_taken_i),
    .insn_valid_i       (insn_valid_i),
    .insn_priv_i        (insn_priv_i),
    .insn_undef_i       (insn_undef_i),
    .insn_chan_i        (insn_chan_i),
    .chanproc_present_i (chanproc_present_i),
    .cmd_user_i         (cmd_user_i),
    .user_mode_o        (user_mode_o),
    .exec_inhibit_o     (exec_inhibit_o),
    .trap_req_o         (trap_req_o),
    .pv_flag_o          (pv_flag_o),
    .eflag_wr_o         (eflag_wr_o),
    .ie_set_o           (ie_set_o)
);

// File: tb/priv_trap_ctrl_tb_top.sv
// Bench for priv_trap_ctrl: vector table walk, then directed tests.
module priv_trap_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_i = 1'b0, irq_taken_i = 1'b0;
    logic insn_valid_i = 1'b0, insn_priv_i = 1'b0, insn_undef_i = 1'b0;
    logic insn_chan_i = 1'b0, insn_eflag_i = 1'b0, chanproc_present_i = 1'b0;
    logic cmd_user_i = 1'b0, cmd_test_mode_i = 1'b0;
    logic cmd_test_pv_i = 1'b0, cmd_clr_pv_i = 1'b0;
    logic user_mode_o, exec_inhibit_o, trap_req_o, pv_flag_o;
    logic eflag_wr_o, ie_set_o, zflag_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    priv_trap_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .irq_taken_i(irq_taken_i),
        .insn_valid_i(insn_valid_i), .insn_priv_i(insn_priv_i),
        .insn_undef_i(insn_undef_i), .insn_chan_i(insn_chan_i),
        .insn_eflag_i(insn_eflag_i), .chanproc_present_i(chanproc_present_i),
        .cmd_user_i(cmd_user_i), .cmd_test_mode_i(cmd_test_mode_i),
        .cmd_test_pv_i(cmd_test_pv_i), .cmd_clr_pv_i(cmd_clr_pv_i),
        .user_mode_o(user_mode_o), .exec_inhibit_o(exec_inhibit_o),
        .trap_req_o(trap_req_o), .pv_flag_o(pv_flag_o),
        .eflag_wr_o(eflag_wr_o), .ie_set_o(ie_set_o), .zflag_o(zflag_o)
    );

    // {user, valid, priv, undef, chan, present, eflag, exp_trap, exp_inh, exp_ewr}
    localparam int NVEC = 10;
    localparam logic [9:0] VECS [NVEC] = '{
        10'b0_1_1_0_0_0_0_000,
        10'b1_1_1_0_0_0_0_110,
        10'b0_1_0_1_0_0_0_110,
        10'b1_1_0_1_0_0_0_110,
        10'b0_1_0_0_1_0_0_110,
        10'b1_1_0_0_1_1_0_000,
        10'b0_1_0_0_0_0_1_001,
        10'b1_1_0_0_0_0_1_000,
        10'b1_0_1_0_0_0_0_000,
        10'b0_1_0_0_1_1_0_000
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic idle();
        init_i = 0; irq_taken_i = 0; insn_valid_i = 0; insn_priv_i = 0;
        insn_undef_i = 0; insn_chan_i = 0; insn_eflag_i = 0;
        cmd_user_i = 0; cmd_test_mode_i = 0; cmd_test_pv_i = 0; cmd_clr_pv_i = 0;
    endtask

    // end the current drive cycle: clock edge, then clear inputs
    task automatic tick();
        @(posedge clk); #1; idle();
    endtask

    task automatic go_monitor();
        init_i = 1; cmd_clr_pv_i = 1; tick();
    endtask

    task automatic go_user();
        go_monitor();
        cmd_user_i = 1; tick();
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL R1 watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        chk("R1 mode in reset", user_mode_o, 1'b0);
        chk("R1 pv in reset", pv_flag_o, 1'b0);
        @(posedge clk); #1; rst_n = 1;
        @(negedge clk);
        chk("R1 mode after reset", user_mode_o, 1'b0);
        chk("R1 pv after reset", pv_flag_o, 1'b0);
        chk("R1 trap after reset", trap_req_o, 1'b0);
        chk("R1 ie_set after reset", ie_set_o, 1'b0);

        // vector table: R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            logic [9:0] v;
            v = VECS[i];
            @(posedge clk); #1;
            if (v[9]) go_user(); else go_monitor();
            insn_valid_i = v[8]; insn_priv_i = v[7]; insn_undef_i = v[6];
            insn_chan_i = v[5]; chanproc_present_i = v[4]; insn_eflag_i = v[3];
            @(negedge clk);
            chk($sformatf("R4 R5 R6 vec %0d trap", i), trap_req_o, v[2]);
            chk($sformatf("R4 R5 R6 vec %0d inhibit", i), exec_inhibit_o, v[1]);
            chk($sformatf("R7 vec %0d eflag_wr", i), eflag_wr_o, v[0]);
            tick();
            chanproc_present_i = 0;
            @(negedge clk);
            chk($sformatf("R4 R5 vec %0d pv", i), pv_flag_o, v[9] & v[8] & v[7]);
            chk($sformatf("R4 R5 vec %0d mode", i), user_mode_o, v[9] & ~v[2]);
        end

        // R3: enter user mode
        @(posedge clk); #1;
        go_monitor();
        cmd_user_i = 1;
        @(negedge clk);
        chk("R3 ie_set same cycle", ie_set_o, 1'b1);
        tick();
        @(negedge clk);
        chk("R3 user after cmd", user_mode_o, 1'b1);
        cmd_user_i = 1;
        @(negedge clk);
        chk("R3 ie_set ignored in user", ie_set_o, 1'b0);
        tick();

        // R2: interrupt taken returns to monitor
        irq_taken_i = 1; tick();
        @(negedge clk);
        chk("R2 irq to monitor", user_mode_o, 1'b0);
        cmd_user_i = 1; tick();
        init_i = 1; tick();
        @(negedge clk);
        chk("R2 init to monitor", user_mode_o, 1'b0);

        // R8 / R9: flag test and clear
        cmd_test_mode_i = 1;
        @(negedge clk);
        chk("R8 test mode monitor", zflag_o, 1'b1);
        tick();
        cmd_user_i = 1; tick();
        insn_valid_i = 1; insn_priv_i = 1; tick();
        cmd_test_pv_i = 1;
        @(negedge clk);
        chk("R8 test pv set", zflag_o, 1'b1);
        tick();
        cmd_user_i = 1; tick();
        cmd_test_mode_i = 1;
        @(negedge clk);
        chk("R8 test mode in user", zflag_o, 1'b0);
        tick();
        cmd_clr_pv_i = 1; tick();
        @(negedge clk);
        chk("R8 clear ignored in user", pv_flag_o, 1'b1);
        irq_taken_i = 1; tick();
        cmd_clr_pv_i = 1; tick();
        @(negedge clk);
        chk("R9 clear in monitor", pv_flag_o, 1'b0);
        cmd_test_pv_i = 1;
        @(negedge clk);
        chk("R8 test pv clear", zflag_o, 1'b0);
        tick();

        // R10: trap beats cmd_user
        cmd_user_i = 1; insn_valid_i = 1; insn_undef_i = 1;
        @(negedge clk);
        chk("R10 trap raised", trap_req_o, 1'b1);
        chk("R10 no ie_set", ie_set_o, 1'b0);
        tick();
        @(negedge clk);
        chk("R10 stays monitor", user_mode_o, 1'b0);
        chk("R5 undef leaves pv", pv_flag_o, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule